// File: doc/BRIEF.md
# 64-bit Integer Execute Unit

This block is the integer execute stage of a load/store RISC datapath. Each cycle it takes a 5-bit operation code, a 64-bit first operand and a second operand. The second operand is either a 64-bit register value or an 8-bit unsigned literal, selected by a flag. The block produces one 64-bit result.

The arithmetic operations are add, subtract and scaled add or subtract, where the first operand is multiplied by 4 or 8 first. Each arithmetic operation comes in a 64-bit form and in a 32-bit form whose result is sign-extended to 64 bits. The block also has six bitwise operations, three of which complement the second operand, and three shifts. None of the operations raises flags or traps; overflow wraps silently.

The result and an illegal-operation flag are captured in an output register when the input valid strobe is high. The output valid flag is the input strobe delayed by one cycle, which lets a pipeline check the result cycle by cycle.

Top module: `int_exec_unit`

## Requirements
- R1: When `use_lit` is 1, the second operand B is `lit_b` zero-extended to 64 bits and `src_b` is ignored. When `use_lit` is 0, B is `src_b`.
- R2: Code 0 gives `src_a + B` and code 2 gives `src_a - B`. Both are computed on all 64 bits and wrap modulo 2^64.
- R3: Code 1 (32-bit add) and code 3 (32-bit subtract) are computed on the low 32 bits only. Bit 31 of the 32-bit result is copied into result bits 63:32. Upper input bits have no effect.
- R4: The 64-bit scaled codes are 4 (A×4 + B), 6 (A×8 + B), 8 (A×4 − B) and 10 (A×8 − B). Each wraps modulo 2^64.
- R5: The 32-bit scaled codes are 5 (A×4 + B), 7 (A×8 + B), 9 (A×4 − B) and 11 (A×8 − B). Scaling acts on the low 32 bits, so bits carried past bit 31 are lost. The 32-bit sum or difference is then sign-extended from bit 31.
- R6: The bitwise codes act on all 64 bits:
  - 16 gives A & B
  - 17 gives A | B
  - 18 gives A ^ B
  - 19 gives A & ~B
  - 20 gives A | ~B
  - 21 gives A ^ ~B
- R7: The shift amount is B[5:0], which is B modulo 64. The shift codes act on all 64 bits:
  - 24 is a left shift with zero fill
  - 25 is a right shift with zero fill
  - 26 is a right shift that fills with A[63]
- R8: Codes 12–15, 22, 23 and 27–31 are illegal. They give result 0 with `illegal` set to 1. Every other code gives `illegal` 0.
- R9: On a rising edge where `in_valid` is 1, `result` and `illegal` take the values for the current inputs. On any other edge they hold. `out_valid` always equals `in_valid` from the previous edge.
- R10: While `rst_n` is low, `out_valid`, `result` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input strobe; captures the result |
| op | input | 5 | Operation code |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand, register form |
| lit_b | input | 8 | Second operand, literal form |
| use_lit | input | 1 | Selects `lit_b` as the second operand |
| out_valid | output | 1 | `in_valid` delayed by one cycle |
| result | output | 64 | Registered result |
| illegal | output | 1 | Registered illegal-operation flag |

## Verification
Two functions fall in the same cycle when a literal is the second operand and also serves as the shift amount. Only the low six bits of the zero-extended literal may count in that case. The bench provokes this with a right shift by literal 200 and expects a shift of 8. It provokes the register form of the same overlap with a left shift by 65 and expects a shift of 1.

A second overlap occurs when 32-bit scaling carries past bit 31 in the same operation as the sign extension. This is provoked by scaling 0x2000_0000 by 8 and by 4. The expected results are the wrapped sum 5 and the negative value 0xFFFF_FFFF_8000_0000.

// File: rtl/exec_pkg.sv
package exec_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD64   = 5'd0,
        OP_ADD32   = 5'd1,
        OP_SUB64   = 5'd2,
        OP_SUB32   = 5'd3,
        OP_S4ADD64 = 5'd4,
        OP_S4ADD32 = 5'd5,
        OP_S8ADD64 = 5'd6,
        OP_S8ADD32 = 5'd7,
        OP_S4SUB64 = 5'd8,
        OP_S4SUB32 = 5'd9,
        OP_S8SUB64 = 5'd10,
        OP_S8SUB32 = 5'd11,
        OP_AND     = 5'd16,
        OP_OR      = 5'd17,
        OP_XOR     = 5'd18,
        OP_ANDN    = 5'd19,
        OP_ORN     = 5'd20,
        OP_XNOR    = 5'd21,
        OP_SHL     = 5'd24,
        OP_SHR     = 5'd25,
        OP_SAR     = 5'd26
    } op_e;

    typedef enum logic [1:0] {
        U_NONE  = 2'd0,
        U_ARITH = 2'd1,
        U_LOGIC = 2'd2,
        U_SHIFT = 2'd3
    } unit_e;

    // scale: 0 = none, 1 = times 4, 2 = times 8
    typedef struct packed {
        unit_e      unit;
        logic       w32;
        logic [1:0] scale;
        logic       sub;
        logic [2:0] fn;
    } op_dec_t;

    function automatic op_dec_t decode_op(logic [OP_W-1:0] op);
        op_dec_t d;
        d = '0;
        if (op < 5'd12) begin
            d.unit = U_ARITH;
            d.w32  = op[0];
            case (op[3:1])
                3'd1:    d.sub = 1'b1;
                3'd2:    d.scale = 2'd1;
                3'd3:    d.scale = 2'd2;
                3'd4:    begin d.scale = 2'd1; d.sub = 1'b1; end
                3'd5:    begin d.scale = 2'd2; d.sub = 1'b1; end
                default: ;
            endcase
        end else if (op >= 5'd16 && op <= 5'd21) begin
            d.unit = U_LOGIC;
            d.fn   = op[2:0];
        end else if (op >= 5'd24 && op <= 5'd26) begin
            d.unit = U_SHIFT;
            d.fn   = {1'b0, op[1:0]};
        end
        return d;
    endfunction

endpackage

// File: rtl/exec_arith.sv
module exec_arith #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              w32,
    input  logic [1:0]        scale,
    input  logic              sub,
    output logic [DATA_W-1:0] y
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] a_sc;
    logic [DATA_W-1:0] sum;

    always_comb begin
        case (scale)
            2'd1:    a_sc = a << 2;
            2'd2:    a_sc = a << 3;
            default: a_sc = a;
        endcase
        sum = sub ? (a_sc - b) : (a_sc + b);
        // the low half of the wide sum equals the sum of the low halves
        if (w32) begin
            y = {{HALF_W{sum[HALF_W-1]}}, sum[HALF_W-1:0]};
        end else begin
            y = sum;
        end
    end
endmodule

// File: rtl/exec_logic.sv
module exec_logic #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [2:0]        fn,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        case (fn)
            3'd0:    y = a & b;
            3'd1:    y = a | b;
            3'd2:    y = a ^ b;
            3'd3:    y = a & ~b;
            3'd4:    y = a | ~b;
            3'd5:    y = a ^ ~b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/exec_shift.sv
module exec_shift #(
    parameter int DATA_W  = 64,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  a,
    input  logic [SHAMT_W-1:0] amt,
    input  logic [1:0]         sel,   // 0 left, 1 right logical, 2 right arithmetic
    output logic [DATA_W-1:0]  y
);
    logic              go_left;
    logic              fill;
    logic [DATA_W-1:0] a_rev;
    logic [DATA_W-1:0] core_in;
    logic [DATA_W-1:0] core_out;
    logic [DATA_W-1:0] out_rev;
    logic [DATA_W-1:0] stage [0:SHAMT_W];

    assign go_left = (sel == 2'd0);
    assign fill    = (sel == 2'd2) ? a[DATA_W-1] : 1'b0;

    // a left shift is a right shift of the bit-reversed word
    for (genvar j = 0; j < DATA_W; j++) begin : g_rev
        assign a_rev[j]   = a[DATA_W-1-j];
        assign out_rev[j] = core_out[DATA_W-1-j];
    end

    assign core_in  = go_left ? a_rev : a;
    assign stage[0] = core_in;

    for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign stage[i+1] = amt[i] ? {{STEP{fill}}, stage[i][DATA_W-1:STEP]}
                                   : stage[i];
    end

    assign core_out = stage[SHAMT_W];
    assign y        = go_left ? out_rev : core_out;
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import exec_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LIT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [LIT_W-1:0]  lit_b,
    input  logic              use_lit,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal
);
    localparam int SHAMT_W = $clog2(DATA_W);

    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic [DATA_W-1:0] result;
    } out_st_t;

    out_st_t           st_d, st_q;
    op_dec_t           dec;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] arith_y, logic_y, shift_y;
    logic [DATA_W-1:0] sel_y;

    assign dec   = decode_op(op);
    assign b_eff = use_lit ? {{(DATA_W-LIT_W){1'b0}}, lit_b} : src_b;

    exec_arith #(.DATA_W(DATA_W)) u_arith (
        .a     (src_a),
        .b     (b_eff),
        .w32   (dec.w32),
        .scale (dec.scale),
        .sub   (dec.sub),
        .y     (arith_y)
    );

    exec_logic #(.DATA_W(DATA_W)) u_logic (
        .a  (src_a),
        .b  (b_eff),
        .fn (dec.fn),
        .y  (logic_y)
    );

    exec_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .a   (src_a),
        .amt (b_eff[SHAMT_W-1:0]),
        .sel (dec.fn[1:0]),
        .y   (shift_y)
    );

    always_comb begin
        case (dec.unit)
            U_ARITH: sel_y = arith_y;
            U_LOGIC: sel_y = logic_y;
            U_SHIFT: sel_y = shift_y;
            default: sel_y = '0;
        endcase

        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result  = sel_y;
            st_d.illegal = (dec.unit == U_NONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.result;
    assign illegal   = st_q.illegal;
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk
    import exec_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LIT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [LIT_W-1:0]  lit_b,
    input logic              use_lit,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              illegal
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] b_view;
    logic              is_w32_arith;
    assign b_view       = use_lit ? {{(DATA_W-LIT_W){1'b0}}, lit_b} : src_b;
    assign is_w32_arith = (op < 5'd12) && op[0];

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(illegal)));

    a_r8_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0));

    a_r3_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_w32_arith) |=> (result[DATA_W-1:HALF_W] == {HALF_W{result[HALF_W-1]}}));

    a_r7_zero_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SHL && use_lit && lit_b[5:0] == 6'd0) |=> (result == $past(src_a)));

    a_r6_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_XOR) |=> (result == ($past(src_a) ^ $past(b_view)) && !illegal));
endmodule

bind int_exec_unit int_exec_unit_chk #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .src_a     (src_a),
    .src_b     (src_b),
    .lit_b     (lit_b),
    .use_lit   (use_lit),
    .out_valid (out_valid),
    .result    (result),
    .illegal   (illegal)
);

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [7:0]  lit_b = '0;
    logic        use_lit = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .lit_b(lit_b), .use_lit(use_lit),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] sx(logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // one valid cycle, checked at the following falling edge
    task automatic run(string tag, logic [4:0] o, logic [63:0] a, logic [63:0] b,
                       logic [7:0] l, logic ul, logic [63:0] exp, logic exp_ill);
        @(negedge clk);
        op = o; src_a = a; src_b = b; lit_b = l; use_lit = ul; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R9 valid"}, {63'd0, out_valid}, 64'd1);
        chk({tag, " result"}, result, exp);
        chk({tag, " R8 illegal"}, {63'd0, illegal}, {63'd0, exp_ill});
    endtask

    task automatic t_reset();
        chk("R10 valid", {63'd0, out_valid}, 64'd0);
        chk("R10 result", result, 64'd0);
        chk("R10 illegal", {63'd0, illegal}, 64'd0);
    endtask

    task automatic t_add_sub();
        run("R2 add wrap", 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 1'b0, 64'd0, 1'b0);
        run("R2 neg", 5'd2, 64'd0, 64'd5, 8'd0, 1'b0, -64'sd5, 1'b0);
        run("R3 add32 ovf", 5'd1, 64'h1234_5678_7FFF_FFFF, 64'hAAAA_0000_0000_0001,
            8'd0, 1'b0, sx(32'h8000_0000), 1'b0);
        run("R3 sub32 lit", 5'd3, 64'd0, 64'd0, 8'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run("R3 canon", 5'd1, 64'd0, 64'h0000_0000_8000_0000, 8'd0, 1'b0,
            64'hFFFF_FFFF_8000_0000, 1'b0);
        // R1: src_b is ignored when the literal is selected
        run("R1 lit ignores src_b", 5'd0, 64'd100, 64'hDEAD_BEEF_0000_0000, 8'd255, 1'b1,
            64'd355, 1'b0);
    endtask

    task automatic t_scaled();
        run("R4 s4add", 5'd4, 64'h10, 64'd0, 8'd3, 1'b1, 64'h43, 1'b0);
        run("R4 s8sub", 5'd10, 64'd2, 64'd20, 8'd0, 1'b0, -64'sd4, 1'b0);
        run("R4 s8add big", 5'd6, 64'h2000_0000, 64'd5, 8'd0, 1'b0, 64'h1_0000_0005, 1'b0);
        run("R4 s4sub", 5'd8, 64'd5, 64'd1, 8'd0, 1'b0, 64'd19, 1'b0);
        run("R5 s8add32 wrap", 5'd7, 64'h2000_0000, 64'd0, 8'd5, 1'b1, 64'd5, 1'b0);
        run("R5 s4sub32 neg", 5'd9, 64'h2000_0000, 64'd0, 8'd0, 1'b1,
            64'hFFFF_FFFF_8000_0000, 1'b0);
        run("R5 s4add32", 5'd5, 64'hFFFF_0000_0000_0003, 64'd1, 8'd0, 1'b0, 64'd13, 1'b0);
        run("R5 s8sub32", 5'd11, 64'd1, 64'd9, 8'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    endtask

    task automatic t_logic();
        logic [63:0] a = 64'hF0F0_F0F0_F0F0_F0F0;
        logic [63:0] b = 64'hFF00_FF00_FF00_FF00;
        run("R6 and", 5'd16, a, b, 8'd0, 1'b0, a & b, 1'b0);
        run("R6 or", 5'd17, a, b, 8'd0, 1'b0, a | b, 1'b0);
        run("R6 xor", 5'd18, a, b, 8'd0, 1'b0, a ^ b, 1'b0);
        run("R6 andn lit", 5'd19, 64'h0000_0000_0000_00FF, 64'd0, 8'd3, 1'b1, 64'hFC, 1'b0);
        run("R6 orn zero", 5'd20, 64'd0, b, 8'd0, 1'b0, ~b, 1'b0);
        run("R6 xnor", 5'd21, a, b, 8'd0, 1'b0, a ^ ~b, 1'b0);
    endtask

    task automatic t_shift();
        run("R7 shl mod", 5'd24, 64'h8000_0000_0000_0003, 64'd65, 8'd0, 1'b0, 64'd6, 1'b0);
        run("R7 shr lit200", 5'd25, 64'hFFFF_0000_0000_1200, 64'd0, 8'd200, 1'b1,
            64'h00FF_FF00_0000_0012, 1'b0);
        run("R7 sar neg", 5'd26, 64'h8000_0000_0000_0000, 64'd4, 8'd0, 1'b0,
            64'hF800_0000_0000_0000, 1'b0);
        run("R7 sar pos", 5'd26, 64'h4000_0000_0000_0000, 64'd63, 8'd0, 1'b0, 64'd0, 1'b0);
    endtask

    task automatic t_illegal();
        run("R8 code12", 5'd12, 64'd7, 64'd7, 8'd0, 1'b0, 64'd0, 1'b1);
        run("R8 code31", 5'd31, 64'hFFFF, 64'd1, 8'd0, 1'b0, 64'd0, 1'b1);
        run("R8 code22", 5'd22, 64'd1, 64'd1, 8'd0, 1'b0, 64'd0, 1'b1);
        run("R8 legal after", 5'd0, 64'd1, 64'd1, 8'd0, 1'b0, 64'd2, 1'b0);
    endtask

    task automatic t_hold();
        run("R9 prime", 5'd0, 64'd40, 64'd2, 8'd0, 1'b0, 64'd42, 1'b0);
        @(negedge clk);
        op = 5'd12; src_a = 64'd999; src_b = 64'd1; in_valid = 1'b0;
        @(negedge clk);
        chk("R9 hold valid", {63'd0, out_valid}, 64'd0);
        chk("R9 hold result", result, 64'd42);
        chk("R9 hold illegal", {63'd0, illegal}, 64'd0);
    endtask

    task automatic t_back2back();
        @(negedge clk);
        op = 5'd0; src_a = 64'd10; src_b = 64'd1; use_lit = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        chk("R9 b2b first", result, 64'd11);
        op = 5'd2; src_a = 64'd10; src_b = 64'd3;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 b2b second", result, 64'd7);
        chk("R9 b2b valid", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        chk("R9 b2b drop", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add_sub();
        t_scaled();
        t_logic();
        t_shift();
        t_illegal();
        t_hold();
        t_back2back();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog got hung exp finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule